// File: doc/BRIEF.md
# ADC Host Bus Interface Controller

This block sits between a host parallel bus and a converter core that has several input channels. The host selects the block with an active-low chip select and uses separate active-low write and read strobes. A write puts a 10-bit word into a control register that the host cannot read back. Every write that does not power the block down starts a conversion set. A set is one conversion, or two conversions one after the other when dual-sample mode is on. A read places one of two result registers on the data port. The port has a separate output-enable signal so that the pad ring can build the tri-state driver.

The strobes arrive asynchronously. Each one passes through a two-stage synchronizer before edge detection in the conversion clock domain. The block drives the channel select, the half-scale test flag and the powerdown flag to the core. It pulses start and abort lines to the core and takes back a done pulse with the 10-bit result. A single active-low status pin works in one of two modes. In busy mode it is low while a set is running. In interrupt mode it goes low when a set completes.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset the control register holds zero, `status_n` is 1, `data_oe` is 0, `power_down` and `half_scale` are 0, and no start pulse is issued.
- R2: `data_oe` is 1 exactly while `cs_n` and `rd_n` are both low. Otherwise the data port is not driven.
- R3: A write (rising `wr_n` with `cs_n` low) loads `data_in` into the control register. The field layout is: bits 2:0 first channel, 5:3 second channel, 6 dual-sample, 7 half-scale, 8 powerdown, 9 status mode. Unless bit 8 is 1, the write issues one `conv_start` pulse with `ch_sel` equal to the first channel.
- R4: With bit 6 set, the done of the first conversion stores its result in result register 1. It then issues a second `conv_start` with `ch_sel` equal to the second channel. The second result goes to result register 2.
- R5: With bit 6 clear, every read returns result register 1. With bit 6 set, successive reads return register 1, register 2, register 1, and so on. The sequence restarts at register 1 after every write and after every completed set.
- R6: In busy mode (bit 9 = 0), `status_n` is low from the start pulse until the set completes or is aborted, and high otherwise.
- R7: In interrupt mode (bit 9 = 1), `status_n` goes low when a set completes. It returns high on the falling edge of `wr_n` or `rd_n` while `cs_n` is low.
- R8: A read that begins while a set runs pulses `conv_abort` and ends the set. Neither result register changes, and in busy mode `status_n` returns high.
- R9: A write during a running set pulses `conv_abort` and starts a fresh set from the new control word.
- R10: A write with bit 8 set aborts any running set, starts nothing, and drives `status_n` high. The result registers keep their values and stay readable.
- R11: A write with bit 8 clear that follows powerdown clears `power_down` and starts a new set, two conversions when bit 6 is set.
- R12: `half_scale` follows bit 7 of the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| data_in | input | 10 | Data port, inbound half |
| data_out | output | 10 | Data port, outbound half (selected result register) |
| data_oe | output | 1 | Data port driver enable |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_abort | output | 1 | One-cycle abort pulse to the converter core |
| ch_sel | output | 3 | Channel to acquire, valid with `conv_start` |
| half_scale | output | 1 | Convert the reference level instead of a channel |
| power_down | output | 1 | Linear circuitry off |
| conv_done | input | 1 | One-cycle pulse from the core when a conversion ends |
| conv_result | input | 10 | Two's complement result, valid with `conv_done` |
| status_n | output | 1 | Busy or interrupt flag, active low |

## Verification
A read pointer that is stuck or not restarted shows at the port on the next read. In dual mode that read returns register 2 where register 1 is expected, or the reverse. A sequencer state left running after an abort shows as `status_n` held low in busy mode, and a stray second `conv_start` reaches the core within a few cycles. A control word latched late or partly shows on `ch_sel` at the very next start pulse. A wrong interrupt flag shows as `status_n` failing to fall at completion, or failing to rise about three cycles after a strobe falls.

// File: rtl/adc_bus_pkg.sv
`timescale 1ns/1ps
package adc_bus_pkg;
    localparam int DATA_W  = 10;
    localparam int CH_W    = 3;
    localparam int NUM_STB = 3;
    localparam int STB_CS  = 2;
    localparam int STB_WR  = 1;
    localparam int STB_RD  = 0;

    // Control word; the bit order is what the host writes.
    typedef struct packed {
        logic            irq_mode;
        logic            pwr_down;
        logic            half_scale;
        logic            dual;
        logic [CH_W-1:0] ch_b;
        logic [CH_W-1:0] ch_a;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_CONV_A = 2'd1,
        SEQ_CONV_B = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_strobe_sync.sv
`timescale 1ns/1ps
module adc_strobe_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] pipe;
        logic [N-1:0]             prev;
    } sync_reg_t;

    sync_reg_t q, d;

    always_comb begin
        d         = q;
        d.pipe[0] = pin;
        for (int s = 1; s < STAGES; s++) begin
            d.pipe[s] = q.pipe[s-1];
        end
        d.prev = q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign lvl  = q.pipe[STAGES-1];
    assign rise = q.pipe[STAGES-1] & ~q.prev;
    assign fall = ~q.pipe[STAGES-1] & q.prev;
endmodule

// File: rtl/adc_conv_seq.sv
`timescale 1ns/1ps
module adc_conv_seq
    import adc_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic              rd_begin,
    input  logic              strobe_fall,
    input  logic [DATA_W-1:0] data_in,
    input  logic              conv_done,
    output ctrl_t             ctrl,
    output logic              conv_start,
    output logic              conv_abort,
    output logic [CH_W-1:0]   ch_sel,
    output logic              status_n,
    output logic              load_a,
    output logic              load_b,
    output logic              set_done
);
    typedef struct packed {
        seq_state_e      state;
        ctrl_t           ctrl;
        logic [CH_W-1:0] ch;
        logic            start;
        logic            abort;
        logic            irq;
        logic            status_n;
    } seq_reg_t;

    localparam seq_reg_t SEQ_RST = '{
        state:    SEQ_IDLE,
        ctrl:     '0,
        ch:       '0,
        start:    1'b0,
        abort:    1'b0,
        irq:      1'b0,
        status_n: 1'b1
    };

    seq_reg_t q, d;
    ctrl_t    new_ctrl;
    logic     running;

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        d.abort  = 1'b0;
        load_a   = 1'b0;
        load_b   = 1'b0;
        set_done = 1'b0;
        new_ctrl = ctrl_t'(data_in[CTRL_W-1:0]);
        running  = (q.state != SEQ_IDLE);

        if (wr_evt) begin
            d.ctrl  = new_ctrl;
            d.abort = running;
            if (new_ctrl.pwr_down) begin
                d.state = SEQ_IDLE;
            end else begin
                d.state = SEQ_CONV_A;
                d.start = 1'b1;
                d.ch    = new_ctrl.ch_a;
            end
        end else if (rd_begin && running) begin
            d.abort = 1'b1;
            d.state = SEQ_IDLE;
        end else if (conv_done && running) begin
            if (q.state == SEQ_CONV_A) begin
                load_a = 1'b1;
                if (q.ctrl.dual) begin
                    d.state = SEQ_CONV_B;
                    d.start = 1'b1;
                    d.ch    = q.ctrl.ch_b;
                end else begin
                    d.state  = SEQ_IDLE;
                    set_done = 1'b1;
                end
            end else begin
                load_b   = 1'b1;
                d.state  = SEQ_IDLE;
                set_done = 1'b1;
            end
        end

        // Interrupt flag: cleared by a strobe falling edge, set by completion.
        if (strobe_fall) begin
            d.irq = 1'b0;
        end
        if (set_done) begin
            d.irq = 1'b1;
        end
        if (d.ctrl.pwr_down) begin
            d.irq = 1'b0;
        end

        if (d.ctrl.irq_mode) begin
            d.status_n = ~d.irq;
        end else begin
            d.status_n = (d.state == SEQ_IDLE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEQ_RST;
        end else begin
            q <= d;
        end
    end

    assign ctrl       = q.ctrl;
    assign conv_start = q.start;
    assign conv_abort = q.abort;
    assign ch_sel     = q.ch;
    assign status_n   = q.status_n;
endmodule

// File: rtl/adc_result_bank.sv
`timescale 1ns/1ps
module adc_result_bank #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_a,
    input  logic          load_b,
    input  logic [DW-1:0] result,
    input  logic          clr_ptr,
    input  logic          step_ptr,
    input  logic          dual,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [DW-1:0] res_a;
        logic [DW-1:0] res_b;
        logic          ptr;
    } bank_reg_t;

    bank_reg_t q, d;

    always_comb begin
        d = q;
        if (load_a) begin
            d.res_a = result;
        end
        if (load_b) begin
            d.res_b = result;
        end
        if (clr_ptr) begin
            d.ptr = 1'b0;
        end else if (step_ptr && dual) begin
            d.ptr = ~q.ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data = (dual && q.ptr) ? q.res_b : q.res_a;
endmodule

// File: rtl/adc_bus_ctrl.sv
`timescale 1ns/1ps
module adc_bus_ctrl
    import adc_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              conv_start,
    output logic              conv_abort,
    output logic [CH_W-1:0]   ch_sel,
    output logic              half_scale,
    output logic              power_down,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    output logic              status_n
);
    logic [NUM_STB-1:0] stb_pin, stb_lvl, stb_rise, stb_fall;
    logic               sel;
    logic               wr_evt, rd_begin, rd_end, strobe_fall;
    logic               unused_cs_edges;
    logic               load_a, load_b, set_done;
    ctrl_t              ctrl;
    logic               cfg_irq;

    assign stb_pin[STB_CS] = cs_n;
    assign stb_pin[STB_WR] = wr_n;
    assign stb_pin[STB_RD] = rd_n;

    adc_strobe_sync #(.N(NUM_STB), .STAGES(2)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (stb_pin),
        .lvl  (stb_lvl),
        .rise (stb_rise),
        .fall (stb_fall)
    );

    assign sel             = ~stb_lvl[STB_CS];
    assign wr_evt          = sel & stb_rise[STB_WR];
    assign rd_begin        = sel & stb_fall[STB_RD];
    assign rd_end          = sel & stb_rise[STB_RD];
    assign strobe_fall     = sel & (stb_fall[STB_WR] | stb_fall[STB_RD]);
    assign unused_cs_edges = stb_rise[STB_CS] ^ stb_fall[STB_CS];

    adc_conv_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_evt     (wr_evt),
        .rd_begin   (rd_begin),
        .strobe_fall(strobe_fall),
        .data_in    (data_in),
        .conv_done  (conv_done),
        .ctrl       (ctrl),
        .conv_start (conv_start),
        .conv_abort (conv_abort),
        .ch_sel     (ch_sel),
        .status_n   (status_n),
        .load_a     (load_a),
        .load_b     (load_b),
        .set_done   (set_done)
    );

    adc_result_bank #(.DW(DATA_W)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_a  (load_a),
        .load_b  (load_b),
        .result  (conv_result),
        .clr_ptr (wr_evt | set_done),
        .step_ptr(rd_end),
        .dual    (ctrl.dual),
        .rd_data (data_out)
    );

    assign data_oe    = ~cs_n & ~rd_n;
    assign half_scale = ctrl.half_scale;
    assign power_down = ctrl.pwr_down;
    assign cfg_irq    = ctrl.irq_mode;
endmodule

// File: rtl/adc_bus_ctrl_chk.sv
`timescale 1ns/1ps
module adc_bus_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic data_oe,
    input logic conv_start,
    input logic conv_abort,
    input logic status_n,
    input logic power_down,
    input logic irq_mode
);
    p_port_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !data_oe);

    p_no_start_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !power_down);

    p_pd_status_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |-> status_n);

    p_busy_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !irq_mode) |-> !status_n);

    p_abort_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_abort && !conv_start && !irq_mode) |-> status_n);
endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .data_oe   (data_oe),
    .conv_start(conv_start),
    .conv_abort(conv_abort),
    .status_n  (status_n),
    .power_down(power_down),
    .irq_mode  (cfg_irq)
);

// File: tb/test_adc_bus_ctrl.sv
`timescale 1ns/1ps
module test_adc_bus_ctrl;
    localparam int LAT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [9:0] data_in = '0;
    logic [9:0] data_out;
    logic       data_oe, conv_start, conv_abort, half_scale, power_down, status_n;
    logic [2:0] ch_sel;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // converter core model
    int       n_start = 0, n_abort = 0;
    logic     pend = 1'b0;
    int       cnt = 0;
    logic [9:0] cur = '0;
    logic [2:0] last_ch = '0;
    logic [5:0] tag = '0;

    always #5 clk = ~clk;

    adc_bus_ctrl i_adc_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .conv_start(conv_start), .conv_abort(conv_abort), .ch_sel(ch_sel),
        .half_scale(half_scale), .power_down(power_down),
        .conv_done(conv_done), .conv_result(conv_result), .status_n(status_n)
    );

    function automatic logic [9:0] exp_res(logic [2:0] ch, logic hs, logic [5:0] t);
        return {ch, hs, t};
    endfunction

    function automatic logic [9:0] mk_ctrl(logic irq, logic pd, logic hs, logic dual,
                                           logic [2:0] cb, logic [2:0] ca);
        return {irq, pd, hs, dual, cb, ca};
    endfunction

    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_abort) n_abort <= n_abort + 1;
        if (conv_start) begin
            n_start <= n_start + 1;
            pend    <= 1'b1;
            cnt     <= LAT;
            cur     <= exp_res(ch_sel, half_scale, tag);
            last_ch <= ch_sel;
        end else if (conv_abort) begin
            pend <= 1'b0;
        end else if (pend) begin
            if (cnt == 1) begin
                conv_done   <= 1'b1;
                conv_result <= cur;
                pend        <= 1'b0;
            end
            cnt <= cnt - 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [9:0] v);
        @(negedge clk);
        cs_n = 1'b0; data_in = v;
        ticks(2); wr_n = 1'b0;
        ticks(3); wr_n = 1'b1;
        ticks(3); cs_n = 1'b1;
        ticks(3);
    endtask

    task automatic bus_read(output logic [9:0] v, output logic oe, output logic st);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        ticks(4);
        v = data_out; oe = data_oe; st = status_n;
        rd_n = 1'b1;
        ticks(4); cs_n = 1'b1;
        ticks(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [9:0] v, c, ea, eb;
        logic oe, st;
        int s0, a0;
        void'($urandom(32'h1d5e_a7c3));
        ticks(3);
        rst_n = 1'b1;
        ticks(3);

        // R1 reset state
        check("R1 status", status_n, 1);
        check("R1 oe", data_oe, 0);
        check("R1 pd", power_down, 0);
        check("R1 hs", half_scale, 0);
        check("R1 starts", n_start, 0);

        // R2 port enable
        rd_n = 1'b0; ticks(2);
        check("R2 cs high", data_oe, 0);
        rd_n = 1'b1; ticks(2);

        // random sets (R3 R4 R5 R6 R7 R12)
        for (int i = 0; i < 24; i++) begin
            logic irq, hs, dual;
            logic [2:0] ca, cb;
            irq = 1'($urandom); hs = 1'($urandom); dual = 1'($urandom);
            ca = 3'($urandom); cb = 3'($urandom);
            tag = 6'($urandom);
            s0 = n_start;
            bus_write(mk_ctrl(irq, 1'b0, hs, dual, cb, ca));
            if (!irq) check("R6 busy low", status_n, 0);
            else      check("R7 irq idle high", status_n, 1);
            ticks(60);
            check("R3/R4 start count", n_start - s0, dual ? 2 : 1);
            check("R4 last channel", last_ch, dual ? cb : ca);
            check("R12 half scale", half_scale, hs);
            check("R6/R7 status after set", status_n, irq ? 0 : 1);
            ea = exp_res(ca, hs, tag);
            eb = exp_res(cb, hs, tag);
            for (int k = 0; k < 3; k++) begin
                bus_read(v, oe, st);
                check("R2 oe in read", oe, 1);
                check("R5 read data", v, (dual && k == 1) ? eb : ea);
                if (irq) check("R7 read clears", st, 1);
            end
        end

        // R8 read during a running set
        tag = 6'h15;
        bus_write(mk_ctrl(0, 0, 0, 0, 3'd0, 3'd5));
        ticks(60);
        ea = exp_res(3'd5, 1'b0, 6'h15);
        bus_read(v, oe, st);
        check("R8 baseline", v, ea);
        tag = 6'h2a; s0 = n_start; a0 = n_abort;
        bus_write(mk_ctrl(0, 0, 0, 0, 3'd0, 3'd2));
        bus_read(v, oe, st);
        ticks(60);
        check("R8 abort pulse", n_abort - a0, 1);
        check("R8 single start", n_start - s0, 1);
        check("R8 status high", status_n, 1);
        bus_read(v, oe, st);
        check("R8 result kept", v, ea);

        // R9 write during a running set
        tag = 6'h07; s0 = n_start; a0 = n_abort;
        bus_write(mk_ctrl(0, 0, 0, 0, 3'd0, 3'd1));
        tag = 6'h31;
        bus_write(mk_ctrl(0, 0, 1, 0, 3'd0, 3'd6));
        ticks(60);
        check("R9 abort", n_abort - a0, 1);
        check("R9 starts", n_start - s0, 2);
        bus_read(v, oe, st);
        check("R9 new result", v, exp_res(3'd6, 1'b1, 6'h31));

        // R10 powerdown during a running set
        tag = 6'h0c;
        bus_write(mk_ctrl(0, 0, 0, 1, 3'd3, 3'd4));
        ticks(60);
        ea = exp_res(3'd4, 1'b0, 6'h0c);
        eb = exp_res(3'd3, 1'b0, 6'h0c);
        tag = 6'h3e; s0 = n_start; a0 = n_abort;
        bus_write(mk_ctrl(0, 0, 0, 1, 3'd1, 3'd2));
        bus_write(mk_ctrl(0, 1, 0, 1, 3'd1, 3'd2));
        ticks(60);
        check("R10 abort", n_abort - a0, 1);
        check("R10 no new start", n_start - s0, 1);
        check("R10 pd out", power_down, 1);
        check("R10 status", status_n, 1);
        bus_read(v, oe, st);
        check("R10 reg1 kept", v, ea);
        bus_read(v, oe, st);
        check("R10 reg2 kept", v, eb);

        // R11 leave powerdown with a dual set
        tag = 6'h19; s0 = n_start;
        c = mk_ctrl(0, 0, 0, 1, 3'd7, 3'd0);
        bus_write(c);
        ticks(60);
        check("R11 pd off", power_down, 0);
        check("R11 two starts", n_start - s0, 2);
        bus_read(v, oe, st);
        check("R11 reg1", v, exp_res(3'd0, 1'b0, 6'h19));
        bus_read(v, oe, st);
        check("R11 reg2", v, exp_res(3'd7, 1'b0, 6'h19));

        // R7 write strobe falling edge clears the interrupt
        tag = 6'h22;
        bus_write(mk_ctrl(1, 0, 0, 0, 3'd0, 3'd3));
        ticks(60);
        check("R7 irq asserted", status_n, 0);
        @(negedge clk);
        cs_n = 1'b0; data_in = mk_ctrl(1, 0, 0, 0, 3'd0, 3'd3);
        ticks(2); wr_n = 1'b0;
        ticks(4);
        check("R7 write fall clears", status_n, 1);
        wr_n = 1'b1; ticks(3); cs_n = 1'b1;
        ticks(60);
        check("R7 irq again", status_n, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule